// File: doc/BRIEF.md
# Prioritized Fault Manager with Enable Reset

This block gathers seven digital fault and warning indications from a bridge driver's analog monitors: supply undervoltage lockout, short circuit, open threshold pin, regulator undervoltage, overvoltage, over-temperature and overcurrent. Each indication passes through its own debounce filter. The filtered condition is then sorted as a self-clearing warning, a self-clearing shutdown or a latched fault. The block drives an active-low fault flag, a request to switch all gates off, a sleep request and a 2-bit code for the most urgent active condition.

The enable input sets the operating state. A controller is in one of six states. ST_SLEEP is the low-power state and the reset state. ST_WAKE counts the wake-up delay. ST_RUN is normal operation. ST_HOLD counts a low pulse on enable. ST_LOWCLR is entered once the fault registers have been cleared; enable is still low there. ST_ARM counts the re-arm delay after enable rises.

The transitions are as follows:
- ST_SLEEP goes to ST_WAKE on a rising edge of enable.
- ST_WAKE goes to ST_RUN after WAKE_CYC cycles, or back to ST_SLEEP if enable drops.
- ST_RUN goes to ST_HOLD when enable is low.
- ST_HOLD goes back to ST_RUN if enable returns within GLITCH_CYC cycles. Otherwise it clears the registers and goes to ST_LOWCLR.
- ST_LOWCLR goes to ST_ARM when enable rises, or to ST_SLEEP when enable has been low for SLEEP_CYC+1 cycles.
- ST_ARM goes to ST_RUN after ARM_CYC cycles, or to ST_LOWCLR if enable drops.
- A qualified supply lockout moves every awake state to ST_SLEEP.

Top module: `fault_mgr`

## Requirements
- R1: While reset is applied and afterwards with enable low, sleep_req=1, fault_n=0, gate_kill=1 and prio_code=3.
- R2: fault_n is 1 only in normal operation with no active condition. Any qualified condition, or any state other than normal operation, drives it to 0.
- R3: A raw input is qualified only after it has been seen high on F_x consecutive clock edges, where F_x is that input's filter length. A shorter pulse has no effect on any output, and a drop restarts the count.
- R4: Overvoltage, over-temperature and overcurrent are warnings. Each gives prio_code=2 and fault_n=0 while gate_kill stays 0. Each clears by itself one edge after its raw input drops.
- R5: Regulator undervoltage gives prio_code=2, and an open threshold pin gives prio_code=1. Both set gate_kill=1 and both clear by themselves when the raw input drops.
- R6: A qualified short circuit latches prio_code=1 and gate_kill=1. The latch holds after the raw input drops, until the fault registers are cleared through enable.
- R7: prio_code encodes the highest-priority active condition. The values are 0 for supply lockout, 1 for short circuit or open pin, 2 for regulator undervoltage, overvoltage, over-temperature or overcurrent, and 3 for none.
- R8: An enable low pulse of at most GLITCH_CYC cycles leaves a latched short circuit in place.
- R9: Enable low for more than GLITCH_CYC cycles clears the fault registers, so prio_code becomes 3. fault_n stays 0 until enable rises, and then for ARM_CYC further cycles.
- R10: Enable low for SLEEP_CYC+1 cycles sets sleep_req. After the next rising edge of enable, normal operation resumes WAKE_CYC+1 edges later.
- R11: A qualified supply lockout forces sleep with prio_code=0. The block stays asleep, even with enable high, until enable goes low and then high again.
- R12: Enable sampled low sets gate_kill=1 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drv_enable | input | 1 | Enable, high to operate |
| uv_supply | input | 1 | Raw supply undervoltage lockout |
| short_det | input | 1 | Raw short-circuit detection |
| thr_open | input | 1 | Raw open threshold pin |
| uv_reg | input | 1 | Raw regulator undervoltage |
| ov_supply | input | 1 | Raw overvoltage |
| ot_warn | input | 1 | Raw over-temperature |
| oc_warn | input | 1 | Raw overcurrent |
| fault_n | output | 1 | Active-low fault flag |
| gate_kill | output | 1 | Request to switch every gate off |
| sleep_req | output | 1 | Request to enter low-power sleep |
| prio_code | output | 2 | Highest-priority active condition code |

## Verification
Each result has a fixed latency from its stimulus:
- A warning, regulator undervoltage or open pin reaches the outputs on the edge that completes its filter count.
- A short circuit reaches them one edge later, and a supply lockout reaches sleep one edge later.
- gate_kill follows enable low by one edge.
- The clear comes on edge GLITCH_CYC+1 of a low pulse, and sleep on edge SLEEP_CYC+1.
- Normal operation returns ARM_CYC+1 or WAKE_CYC+1 edges after enable rises.

The bench drives inputs at the falling edge and counts rising edges. For each timed result it samples one or more edges before the due edge to show it has not yet happened, and two edges after to show it has. Random patterns hold each input for a random count. The expected outputs come from comparing that count with each filter length.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_WAKE,
        ST_ARM,
        ST_RUN,
        ST_HOLD,
        ST_LOWCLR
    } fm_state_e;

    localparam int NUM_FLT   = 7;
    localparam int IDX_UVLO  = 0;
    localparam int IDX_SHORT = 1;
    localparam int IDX_OPEN  = 2;
    localparam int IDX_VREG  = 3;
    localparam int IDX_OVOLT = 4;
    localparam int IDX_OTEMP = 5;
    localparam int IDX_OCUR  = 6;

    localparam logic [1:0] CODE_SUPPLY = 2'd0;
    localparam logic [1:0] CODE_SEVERE = 2'd1;
    localparam logic [1:0] CODE_WARN   = 2'd2;
    localparam logic [1:0] CODE_NONE   = 2'd3;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/fm_filter.sv
module fm_filter #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic raw,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // saturating run-length count; any dropout restarts it
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!enable || !raw)  cnt_q <= '0;
        else if (cnt_q != LIM_V)   cnt_q <= cnt_q + CW'(1);
    end

    assign hit = (cnt_q == LIM_V);
endmodule

// File: rtl/fm_enable_fsm.sv
module fm_enable_fsm
    import fm_pkg::*;
#(
    parameter int unsigned GLITCH_CYC = 240,
    parameter int unsigned ARM_CYC    = 1150,
    parameter int unsigned SLEEP_CYC  = 83000,
    parameter int unsigned WAKE_CYC   = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic uvlo_hit,
    output logic running,
    output logic filt_on,
    output logic sup_on,
    output logic asleep,
    output logic clr_regs,
    output logic wake_go
);
    localparam int unsigned TOP_CNT = max4(GLITCH_CYC, ARM_CYC, SLEEP_CYC, WAKE_CYC);
    localparam int CW = $clog2(TOP_CNT + 2);
    localparam logic [CW-1:0] G_V = CW'(GLITCH_CYC);
    localparam logic [CW-1:0] A_V = CW'(ARM_CYC - 1);
    localparam logic [CW-1:0] S_V = CW'(SLEEP_CYC);
    localparam logic [CW-1:0] W_V = CW'(WAKE_CYC - 1);

    fm_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
            cnt_q   <= '0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            en_q    <= en;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SLEEP: begin
                if (en && !en_q) begin
                    state_d = ST_WAKE;
                    cnt_d   = '0;
                end
            end
            ST_WAKE: begin
                if (uvlo_hit || !en)  state_d = ST_SLEEP;
                else if (cnt_q == W_V) state_d = ST_RUN;
                else                   cnt_d = cnt_q + CW'(1);
            end
            ST_ARM: begin
                if (uvlo_hit)          state_d = ST_SLEEP;
                else if (!en) begin
                    state_d = ST_LOWCLR;
                    cnt_d   = CW'(1);
                end
                else if (cnt_q == A_V) state_d = ST_RUN;
                else                   cnt_d = cnt_q + CW'(1);
            end
            ST_RUN: begin
                if (uvlo_hit)          state_d = ST_SLEEP;
                else if (!en) begin
                    state_d = ST_HOLD;
                    cnt_d   = CW'(1);
                end
            end
            ST_HOLD: begin
                if (uvlo_hit)          state_d = ST_SLEEP;
                else if (en)           state_d = ST_RUN;
                else begin
                    if (cnt_q == G_V) state_d = ST_LOWCLR;
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_LOWCLR: begin
                if (uvlo_hit)          state_d = ST_SLEEP;
                else if (en) begin
                    state_d = ST_ARM;
                    cnt_d   = '0;
                end
                else if (cnt_q == S_V) state_d = ST_SLEEP;
                else                   cnt_d = cnt_q + CW'(1);
            end
            default: state_d = ST_SLEEP;
        endcase
    end

    always_comb begin
        running  = (state_q == ST_RUN);
        asleep   = (state_q == ST_SLEEP);
        sup_on   = !asleep;
        clr_regs = (state_q == ST_HOLD) && !en && !uvlo_hit && (cnt_q == G_V);
        wake_go  = asleep && en && !en_q;
        filt_on  = ((state_q == ST_RUN) || (state_q == ST_HOLD)) && !clr_regs;
    end
endmodule

// File: rtl/fm_fault_core.sv
module fm_fault_core
    import fm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_FLT-1:0] hit,
    input  logic               clr_all,
    input  logic               running,
    output logic               fault_n,
    output logic               gate_kill,
    output logic [1:0]         code
);
    logic uvlo_lat, scd_lat;
    logic severe, warn;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uvlo_lat <= 1'b0;
            scd_lat  <= 1'b0;
        end else if (clr_all) begin
            uvlo_lat <= 1'b0;
            scd_lat  <= 1'b0;
        end else begin
            if (hit[IDX_UVLO])  uvlo_lat <= 1'b1;
            if (hit[IDX_SHORT]) scd_lat  <= 1'b1;
        end
    end

    always_comb begin
        severe = scd_lat || hit[IDX_OPEN];
        warn   = hit[IDX_VREG] || hit[IDX_OVOLT] || hit[IDX_OTEMP] || hit[IDX_OCUR];
        if (uvlo_lat)    code = CODE_SUPPLY;
        else if (severe) code = CODE_SEVERE;
        else if (warn)   code = CODE_WARN;
        else             code = CODE_NONE;
        fault_n   = running && (code == CODE_NONE);
        gate_kill = !running || uvlo_lat || severe || hit[IDX_VREG];
    end
endmodule

// File: rtl/fault_mgr.sv
module fault_mgr
    import fm_pkg::*;
#(
    parameter int unsigned GLITCH_CYC = 240,
    parameter int unsigned ARM_CYC    = 1150,
    parameter int unsigned SLEEP_CYC  = 83000,
    parameter int unsigned WAKE_CYC   = 20000,
    parameter int unsigned F_UVLO     = 4000,
    parameter int unsigned F_SHORT    = 400,
    parameter int unsigned F_OPEN     = 500,
    parameter int unsigned F_VREG     = 4000,
    parameter int unsigned F_OVOLT    = 3800,
    parameter int unsigned F_OTEMP    = 2000,
    parameter int unsigned F_OCUR     = 660
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       drv_enable,
    input  logic       uv_supply,
    input  logic       short_det,
    input  logic       thr_open,
    input  logic       uv_reg,
    input  logic       ov_supply,
    input  logic       ot_warn,
    input  logic       oc_warn,
    output logic       fault_n,
    output logic       gate_kill,
    output logic       sleep_req,
    output logic [1:0] prio_code
);
    localparam int unsigned FLT_LIM [NUM_FLT] =
        '{F_UVLO, F_SHORT, F_OPEN, F_VREG, F_OVOLT, F_OTEMP, F_OCUR};

    logic [NUM_FLT-1:0] raw, hit;
    logic running, filt_on, sup_on, asleep, clr_regs, wake_go;

    assign raw = {oc_warn, ot_warn, ov_supply, uv_reg, thr_open, short_det, uv_supply};

    for (genvar gi = 0; gi < NUM_FLT; gi++) begin : g_flt
        localparam bit IS_SUPPLY = (gi == IDX_UVLO);
        fm_filter #(.LIMIT(FLT_LIM[gi])) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (IS_SUPPLY ? sup_on : filt_on),
            .raw    (raw[gi]),
            .hit    (hit[gi])
        );
    end

    fm_enable_fsm #(
        .GLITCH_CYC (GLITCH_CYC),
        .ARM_CYC    (ARM_CYC),
        .SLEEP_CYC  (SLEEP_CYC),
        .WAKE_CYC   (WAKE_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (drv_enable),
        .uvlo_hit (hit[IDX_UVLO]),
        .running  (running),
        .filt_on  (filt_on),
        .sup_on   (sup_on),
        .asleep   (asleep),
        .clr_regs (clr_regs),
        .wake_go  (wake_go)
    );

    fm_fault_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .clr_all   (clr_regs || wake_go),
        .running   (running),
        .fault_n   (fault_n),
        .gate_kill (gate_kill),
        .code      (prio_code)
    );

    assign sleep_req = asleep;
endmodule

// File: rtl/fm_checker.sv
module fm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       drv_enable,
    input logic       fault_n,
    input logic       gate_kill,
    input logic       sleep_req,
    input logic [1:0] prio_code
);
    assert_quiet_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_n |-> (!gate_kill && !sleep_req && prio_code == 2'd3));

    assert_supply_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_code == 2'd0) |-> (gate_kill && !fault_n));

    assert_sleep_kills_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (gate_kill && !fault_n));

    assert_enable_low_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_enable |=> gate_kill);

    assert_wake_on_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_req) |-> $past(drv_enable));

    assert_severe_kills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_code == 2'd1) |-> gate_kill);
endmodule

bind fault_mgr fm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drv_enable (drv_enable),
    .fault_n    (fault_n),
    .gate_kill  (gate_kill),
    .sleep_req  (sleep_req),
    .prio_code  (prio_code)
);

// File: tb/tb_fault_mgr.sv
`timescale 1ns/1ps
module tb_fault_mgr;
    localparam int G = 6, A = 10, S = 40, W = 12;
    localparam int LUV = 8, LSH = 5, LOP = 4, LVR = 7, LOV = 9, LOT = 3, LOC = 6;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
    logic uvs = 1'b0, sh = 1'b0, op = 1'b0, vr = 1'b0, ov = 1'b0, ot = 1'b0, oc = 1'b0;
    logic fault_n, gate_kill, sleep_req;
    logic [1:0] prio;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fault_mgr #(
        .GLITCH_CYC(G), .ARM_CYC(A), .SLEEP_CYC(S), .WAKE_CYC(W),
        .F_UVLO(LUV), .F_SHORT(LSH), .F_OPEN(LOP), .F_VREG(LVR),
        .F_OVOLT(LOV), .F_OTEMP(LOT), .F_OCUR(LOC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .drv_enable(en),
        .uv_supply(uvs), .short_det(sh), .thr_open(op), .uv_reg(vr),
        .ov_supply(ov), .ot_warn(ot), .oc_warn(oc),
        .fault_n(fault_n), .gate_kill(gate_kill), .sleep_req(sleep_req), .prio_code(prio)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_code(bit a_op, bit a_vr, bit a_ov, bit a_ot, bit a_oc);
        if (a_op) return 1;
        if (a_vr || a_ov || a_ot || a_oc) return 2;
        return 3;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1F2E3D4C);
        tick(3);
        chk("R1", "sleep_req in reset", sleep_req, 1);
        chk("R1", "fault_n in reset", fault_n, 0);
        chk("R1", "gate_kill in reset", gate_kill, 1);
        chk("R1", "prio_code in reset", prio, 3);
        rst_n = 1'b1;
        tick(2);
        chk("R1", "sleep_req after reset, enable low", sleep_req, 1);

        en = 1'b1;
        tick(W);
        chk("R10", "fault_n during wake", fault_n, 0);
        chk("R10", "sleep_req after enable rise", sleep_req, 0);
        tick(2);
        chk("R10", "fault_n after wake", fault_n, 1);
        chk("R2", "gate_kill in clean run", gate_kill, 0);

        // R3: pulse one edge short of the filter
        ov = 1'b1; tick(LOV - 1); ov = 1'b0; tick(1);
        chk("R3", "fault_n after short pulse", fault_n, 1);
        ov = 1'b1; tick(LOV - 1);
        chk("R3", "fault_n before filter done", fault_n, 1);
        tick(2);
        chk("R4", "fault_n overvoltage", fault_n, 0);
        chk("R4", "prio_code overvoltage", prio, 2);
        chk("R4", "gate_kill overvoltage", gate_kill, 0);
        ov = 1'b0; tick(2);
        chk("R4", "fault_n self-clear", fault_n, 1);

        vr = 1'b1; tick(LVR + 2);
        chk("R5", "gate_kill reg uv", gate_kill, 1);
        chk("R5", "prio_code reg uv", prio, 2);
        vr = 1'b0; tick(2);
        chk("R5", "gate_kill reg uv clear", gate_kill, 0);
        op = 1'b1; tick(LOP + 2);
        chk("R5", "gate_kill open pin", gate_kill, 1);
        chk("R5", "prio_code open pin", prio, 1);
        op = 1'b0; tick(2);
        chk("R5", "fault_n open pin clear", fault_n, 1);

        sh = 1'b1; tick(LSH + 3); sh = 1'b0;
        chk("R6", "prio_code short", prio, 1);
        chk("R6", "gate_kill short", gate_kill, 1);
        tick(10);
        chk("R6", "short stays latched", prio, 1);
        chk("R6", "fault_n short latched", fault_n, 0);

        en = 1'b0; tick(G); en = 1'b1; tick(2);
        chk("R8", "short kept after glitch", prio, 1);
        chk("R8", "fault_n after glitch", fault_n, 0);

        en = 1'b0; tick(1);
        chk("R12", "gate_kill after enable low", gate_kill, 1);
        tick(G + 4);
        chk("R9", "prio_code cleared", prio, 3);
        chk("R9", "fault_n while enable low", fault_n, 0);
        en = 1'b1; tick(A - 1);
        chk("R9", "fault_n during re-arm", fault_n, 0);
        tick(3);
        chk("R9", "fault_n after re-arm", fault_n, 1);
        chk("R9", "gate_kill after re-arm", gate_kill, 0);

        en = 1'b0; tick(S);
        chk("R10", "no sleep at SLEEP_CYC edges", sleep_req, 0);
        tick(3);
        chk("R10", "sleep after long low", sleep_req, 1);
        en = 1'b1; tick(W);
        chk("R10", "fault_n while waking", fault_n, 0);
        tick(2);
        chk("R10", "fault_n awake", fault_n, 1);

        for (int it = 0; it < 30; it++) begin
            logic [4:0] pat;
            int n;
            bit a_op, a_vr, a_ov, a_ot, a_oc;
            pat = 5'($urandom);
            n = 1 + int'($urandom % 12);
            op = pat[0]; vr = pat[1]; ov = pat[2]; ot = pat[3]; oc = pat[4];
            tick(n);
            a_op = pat[0] && n >= LOP;
            a_vr = pat[1] && n >= LVR;
            a_ov = pat[2] && n >= LOV;
            a_ot = pat[3] && n >= LOT;
            a_oc = pat[4] && n >= LOC;
            chk("R7", "random prio_code", prio, exp_code(a_op, a_vr, a_ov, a_ot, a_oc));
            chk("R3", "random fault_n", fault_n,
                (exp_code(a_op, a_vr, a_ov, a_ot, a_oc) == 3) ? 1 : 0);
            chk("R5", "random gate_kill", gate_kill, (a_op || a_vr) ? 1 : 0);
            op = 1'b0; vr = 1'b0; ov = 1'b0; ot = 1'b0; oc = 1'b0;
            tick(2);
        end

        uvs = 1'b1; sh = 1'b1; tick(LUV + 3);
        chk("R11", "sleep on supply lockout", sleep_req, 1);
        chk("R7", "supply beats short", prio, 0);
        chk("R11", "fault_n supply lockout", fault_n, 0);
        uvs = 1'b0; sh = 1'b0; tick(10);
        chk("R11", "stays asleep with enable high", sleep_req, 1);
        chk("R11", "prio_code held", prio, 0);
        en = 1'b0; tick(2); en = 1'b1; tick(3);
        chk("R11", "woken by enable edge", sleep_req, 0);
        chk("R11", "prio_code cleared on wake", prio, 3);
        tick(W + 1);
        chk("R11", "fault_n after restart", fault_n, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule